// File: doc/BRIEF.md
# E1 Transmit Timing Generator

The block takes a fast oscillator clock and divides it down to a 2.048 MHz transmit serial clock for the terminal equipment that feeds payload. A two-bit select input chooses a prescaler of one, two or four, so that a 16.384, 32.768 or 65.536 MHz oscillator each gives the same 16.384 MHz internal rate. A fixed divide-by-eight after the prescaler then gives the bit clock.

On the same bit clock the block keeps a position counter: 256 bit positions per frame and 16 frames per multiframe. It raises a frame sync pulse for the whole of the final bit of every frame. It raises a multiframe sync pulse for the whole of the final bit of frame 15. The equipment starts loading the next frame or multiframe when it sees these pulses. The pulses and counters change on the rising edge of the serial clock, the edge on which the equipment launches data. All logic runs on the oscillator clock; the serial clock is a registered output.

Top module: `e1_tx_timing_gen`

## Requirements
- R1: The select codes 00, 01 and 10 divide the oscillator by 1, 2 and 4. The serial clock period is then 8, 16 and 32 oscillator cycles.
- R2: The reserved select code 11 behaves exactly like 00, giving a serial clock period of 8 oscillator cycles.
- R3: The serial clock is high for exactly half of its period, 4·N oscillator cycles, where N is the prescale ratio.
- R4: bit_cnt advances by one on each rising edge of the serial clock and wraps from 255 to 0. On that wrap, frame_cnt advances by one and wraps from 15 to 0.
- R5: frame_sync is high exactly while bit_cnt is 255, for one whole serial clock period of every frame.
- R6: mframe_sync is high only while frame_cnt is 15 and bit_cnt is 255, and always together with frame_sync.
- R7: bit_cnt, frame_cnt, frame_sync and mframe_sync change only in the oscillator cycle in which the serial clock rises.
- R8: While rst is high at a clock edge, the next state is ser_clk low, both syncs low and both counters zero. After release, the first serial clock rise appears N oscillator cycles later and shows frame 0, bit 0.
- R9: A change of the select input takes effect only at the next frame boundary. The serial clock keeps its old period up to the rise that starts bit 0 of the next frame, and uses the new period after that rise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| osc_clk | input | 1 | Oscillator clock, 16.384 to 65.536 MHz |
| rst | input | 1 | Synchronous reset, active high |
| div_sel | input | 2 | Prescaler select: 00 = /1, 01 = /2, 10 = /4, 11 = /1 |
| ser_clk | output | 1 | 2.048 MHz transmit serial clock |
| frame_sync | output | 1 | High during the last bit of each frame |
| mframe_sync | output | 1 | High during the last bit of each multiframe |
| bit_cnt | output | 8 | Current bit position in the frame, 0 to 255 |
| frame_cnt | output | 4 | Current frame in the multiframe, 0 to 15 |

## Verification
A wrong prescaler ratio or phase count shows up at the next serial clock edge as a changed period or duty cycle, within 32 oscillator cycles. A bit counter that skips or repeats a value is caught on the very next bit, and a frame counter error shows at the next frame wrap, within 256 bits. A sync pulse decoded at the wrong position is caught in the first frame, and a wrongly decoded multiframe pulse within one full multiframe. A select change that is applied too early is visible as a change of period before rise 257.

// File: rtl/e1tg_pkg.sv
package e1tg_pkg;
    localparam int SER_DIV    = 8;    // internal ticks per serial bit
    localparam int FRAME_BITS = 256;  // bit positions per frame
    localparam int MF_FRAMES  = 16;   // frames per multiframe
    localparam int PRE_MAX    = 4;    // largest prescale ratio

    localparam int PRE_W = $clog2(PRE_MAX);
    localparam int PH_W  = $clog2(SER_DIV);
    localparam int BIT_W = $clog2(FRAME_BITS);
    localparam int FR_W  = $clog2(MF_FRAMES);

    typedef enum logic [1:0] {
        SEL_DIV1 = 2'b00,
        SEL_DIV2 = 2'b01,
        SEL_DIV4 = 2'b10,
        SEL_RSVD = 2'b11
    } div_sel_e;
endpackage

// File: rtl/e1tg_prescaler.sv
module e1tg_prescaler
    import e1tg_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] sel_in,
    input  logic       frame_load,
    output logic       tick
);
    typedef struct packed {
        logic [1:0]       sel;
        logic [PRE_W-1:0] cnt;
    } pre_st_t;

    pre_st_t st_d, st_q;
    logic [PRE_W-1:0] last_cnt;

    // terminal count of the active prescale ratio
    always_comb begin
        case (div_sel_e'(st_q.sel))
            SEL_DIV2: last_cnt = PRE_W'(1);
            SEL_DIV4: last_cnt = PRE_W'(3);
            default:  last_cnt = '0;
        endcase
    end

    assign tick = (st_q.cnt == last_cnt);

    always_comb begin
        st_d = st_q;
        if (rst || frame_load) begin
            st_d.sel = sel_in;
            st_d.cnt = '0;
        end else if (tick) begin
            st_d.cnt = '0;
        end else begin
            st_d.cnt = st_q.cnt + PRE_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end
endmodule

// File: rtl/e1tg_bitclk.sv
module e1tg_bitclk
    import e1tg_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic tick,
    output logic bit_strobe,
    output logic ser_clk
);
    localparam logic [PH_W-1:0] PH_LAST = PH_W'(SER_DIV - 1);
    localparam logic [PH_W-1:0] PH_HALF = PH_W'(SER_DIV / 2);

    typedef struct packed {
        logic [PH_W-1:0] phase;
        logic            sclk;
    } bc_st_t;

    bc_st_t st_d, st_q;

    // asserted in the cycle whose edge raises the serial clock
    assign bit_strobe = tick && (st_q.phase == PH_LAST);
    assign ser_clk    = st_q.sclk;

    always_comb begin
        st_d = st_q;
        if (rst) begin
            st_d.phase = PH_LAST;
            st_d.sclk  = 1'b0;
        end else begin
            if (tick) begin
                st_d.phase = st_q.phase + PH_W'(1);
            end
            st_d.sclk = (st_d.phase < PH_HALF);
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end
endmodule

// File: rtl/e1tg_frame_ctr.sv
module e1tg_frame_ctr
    import e1tg_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             bit_strobe,
    output logic             frame_wrap,
    output logic             fsync,
    output logic             mfsync,
    output logic [BIT_W-1:0] bit_pos,
    output logic [FR_W-1:0]  frame_pos
);
    localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(FRAME_BITS - 1);
    localparam logic [FR_W-1:0]  FR_LAST  = FR_W'(MF_FRAMES - 1);

    typedef struct packed {
        logic             started;
        logic [BIT_W-1:0] bitc;
        logic [FR_W-1:0]  frame;
        logic             fs;
        logic             mfs;
    } fc_st_t;

    fc_st_t st_d, st_q;

    assign frame_wrap = bit_strobe && st_q.started && (st_q.bitc == BIT_LAST);
    assign fsync      = st_q.fs;
    assign mfsync     = st_q.mfs;
    assign bit_pos    = st_q.bitc;
    assign frame_pos  = st_q.frame;

    always_comb begin
        st_d = st_q;
        if (rst) begin
            st_d = '0;
        end else if (bit_strobe) begin
            if (!st_q.started) begin
                st_d.started = 1'b1;
                st_d.bitc    = '0;
                st_d.frame   = '0;
            end else if (st_q.bitc == BIT_LAST) begin
                st_d.bitc  = '0;
                st_d.frame = (st_q.frame == FR_LAST) ? '0 : st_q.frame + FR_W'(1);
            end else begin
                st_d.bitc = st_q.bitc + BIT_W'(1);
            end
            st_d.fs  = (st_d.bitc == BIT_LAST);
            st_d.mfs = (st_d.bitc == BIT_LAST) && (st_d.frame == FR_LAST);
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end
endmodule

// File: rtl/e1_tx_timing_gen.sv
module e1_tx_timing_gen
    import e1tg_pkg::*;
(
    input  logic             osc_clk,
    input  logic             rst,
    input  logic [1:0]       div_sel,
    output logic             ser_clk,
    output logic             frame_sync,
    output logic             mframe_sync,
    output logic [BIT_W-1:0] bit_cnt,
    output logic [FR_W-1:0]  frame_cnt
);
    logic int_tick;
    logic bit_strobe;
    logic frame_wrap;

    e1tg_prescaler u_pre (
        .clk        (osc_clk),
        .rst        (rst),
        .sel_in     (div_sel),
        .frame_load (frame_wrap),
        .tick       (int_tick)
    );

    e1tg_bitclk u_bclk (
        .clk        (osc_clk),
        .rst        (rst),
        .tick       (int_tick),
        .bit_strobe (bit_strobe),
        .ser_clk    (ser_clk)
    );

    e1tg_frame_ctr u_fctr (
        .clk        (osc_clk),
        .rst        (rst),
        .bit_strobe (bit_strobe),
        .frame_wrap (frame_wrap),
        .fsync      (frame_sync),
        .mfsync     (mframe_sync),
        .bit_pos    (bit_cnt),
        .frame_pos  (frame_cnt)
    );
endmodule

// File: rtl/e1tg_checker.sv
module e1tg_checker
    import e1tg_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             ser_clk,
    input logic             frame_sync,
    input logic             mframe_sync,
    input logic [BIT_W-1:0] bit_cnt,
    input logic [FR_W-1:0]  frame_cnt
);
    localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(FRAME_BITS - 1);
    localparam logic [FR_W-1:0]  FR_LAST  = FR_W'(MF_FRAMES - 1);

    // R5
    fsync_at_last_chk: assert property (@(posedge clk) disable iff (rst)
        frame_sync |-> (bit_cnt == BIT_LAST));

    // R5
    last_has_fsync_chk: assert property (@(posedge clk) disable iff (rst)
        (bit_cnt == BIT_LAST) |-> frame_sync);

    // R6
    mfsync_pos_chk: assert property (@(posedge clk) disable iff (rst)
        mframe_sync |-> (frame_sync && frame_cnt == FR_LAST));

    // R7
    hold_between_rises_chk: assert property (@(posedge clk) disable iff (rst)
        !$rose(ser_clk) |-> ($stable(bit_cnt) && $stable(frame_cnt)
                             && $stable(frame_sync) && $stable(mframe_sync)));

    // R4
    bit_step_chk: assert property (@(posedge clk) disable iff (rst)
        ($rose(ser_clk) && bit_cnt != '0) |-> (bit_cnt == $past(bit_cnt) + BIT_W'(1)));

    // R8
    reset_quiet_chk: assert property (@(posedge clk)
        rst |=> (!ser_clk && !frame_sync && !mframe_sync
                 && bit_cnt == '0 && frame_cnt == '0));
endmodule

bind e1_tx_timing_gen e1tg_checker u_e1tg_chk (
    .clk         (osc_clk),
    .rst         (rst),
    .ser_clk     (ser_clk),
    .frame_sync  (frame_sync),
    .mframe_sync (mframe_sync),
    .bit_cnt     (bit_cnt),
    .frame_cnt   (frame_cnt)
);

// File: tb/test_e1_tx_timing_gen.sv
module test_e1_tx_timing_gen;
    localparam time CLK_PERIOD = 10ns;
    localparam int  WATCHDOG   = 200000;

    // columns: select code, prescale ratio N, serial rises to observe
    localparam int VEC_N = 4;
    localparam int VEC [VEC_N][3] = '{
        '{0, 1, 4097},   // R1 /1, full multiframe plus wrap
        '{1, 2, 300},    // R1 /2
        '{2, 4, 300},    // R1 /4
        '{3, 1, 300}     // R2 reserved code
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] div_sel = 2'b00;
    logic       ser_clk, frame_sync, mframe_sync;
    logic [7:0] bit_cnt;
    logic [3:0] frame_cnt;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    e1_tx_timing_gen i_e1_tx_timing_gen (
        .osc_clk     (clk),
        .rst         (rst),
        .div_sel     (div_sel),
        .ser_clk     (ser_clk),
        .frame_sync  (frame_sync),
        .mframe_sync (mframe_sync),
        .bit_cnt     (bit_cnt),
        .frame_cnt   (frame_cnt)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // R8: hold reset, look at the outputs, then release at a falling edge
    task automatic apply_reset(input logic [1:0] sel);
        @(negedge clk);
        rst     = 1'b1;
        div_sel = sel;
        repeat (3) @(negedge clk);
        check(ser_clk == 1'b0, "R8 ser_clk in reset", int'(ser_clk), 0);
        check(frame_sync == 1'b0 && mframe_sync == 1'b0, "R8 syncs in reset",
              int'({frame_sync, mframe_sync}), 0);
        check(bit_cnt == 8'd0 && frame_cnt == 4'd0, "R8 counters in reset",
              int'({frame_cnt, bit_cnt}), 0);
        rst = 1'b0;
    endtask

    // Observe n_rises serial clock rises; periods per_a up to rise 257,
    // per_b afterwards when a select change is made at rise sw_rise.
    task automatic run_bits(input int n_rises, input int ratio, input int per_a,
                            input int per_b, input int sw_rise, input logic [1:0] sw_sel);
        int   rises = 0;
        int   since = 0;
        int   high  = 0;
        logic prev  = 1'b0;
        while (rises < n_rises) begin
            @(negedge clk);
            since++;
            if (ser_clk && !prev) begin
                int per;
                int exp_bit;
                int exp_fr;
                rises++;
                per = (sw_rise > 0 && rises > 257) ? per_b : per_a;
                if (rises == 1) begin
                    check(since == ratio, "R8 first rise delay", since, ratio);
                end else begin
                    check(since == per, "R1/R2/R9 serial period", since, per);
                    check(high == per / 2, "R3 high time", high, per / 2);
                end
                exp_bit = (rises - 1) % 256;
                exp_fr  = ((rises - 1) / 256) % 16;
                check(int'(bit_cnt) == exp_bit, "R4 bit_cnt", int'(bit_cnt), exp_bit);
                check(int'(frame_cnt) == exp_fr, "R4 frame_cnt", int'(frame_cnt), exp_fr);
                check(frame_sync == (exp_bit == 255), "R5 frame_sync",
                      int'(frame_sync), int'(exp_bit == 255));
                check(mframe_sync == (exp_bit == 255 && exp_fr == 15), "R6 mframe_sync",
                      int'(mframe_sync), int'(exp_bit == 255 && exp_fr == 15));
                since = 0;
                high  = 0;
                if (sw_rise > 0 && rises == sw_rise) div_sel = sw_sel;
            end else if (rises > 0) begin
                // R7: nothing moves away from a rising edge
                if (since == 2) begin
                    int exp_bit = (rises - 1) % 256;
                    check(int'(bit_cnt) == exp_bit, "R7 bit_cnt held", int'(bit_cnt), exp_bit);
                end
            end
            if (ser_clk) high++;
            prev = ser_clk;
        end
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=%0d expected=%0d cycles", WATCHDOG, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        // table walk: R1, R2, R3, R4, R5, R6, R8
        for (int v = 0; v < VEC_N; v++) begin
            apply_reset(VEC[v][0][1:0]);
            run_bits(VEC[v][2], VEC[v][1], 8 * VEC[v][1], 8 * VEC[v][1], 0, 2'b00);
        end

        // R9: switch /1 to /2 in the middle of frame 0
        apply_reset(2'b00);
        run_bits(300, 1, 8, 16, 100, 2'b01);

        // R9: switch /4 to /1 in the middle of frame 0
        apply_reset(2'b10);
        run_bits(270, 4, 32, 8, 40, 2'b00);

        // R8: reset in the middle of a run, then a clean restart
        apply_reset(2'b01);
        run_bits(20, 2, 16, 16, 0, 2'b00);
        apply_reset(2'b01);
        run_bits(5, 2, 16, 16, 0, 2'b00);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule